// File: doc/BRIEF.md
# Dual-Channel Memory/Word-Stream DMA Controller

This block moves 32-bit words between memory and a word stream under register control. It has two channels that use the same register layout. The fetch channel reads words from memory and presents them on an outgoing valid/ready stream. The store channel accepts words from an incoming valid/ready stream and writes them to memory. Each channel has its own start address, word count, byte-order option and interrupt logic.

Software loads a channel's address and optional control settings, then writes a non-zero byte count to start it. The channel clears its busy bit after the final word and raises a completion flag. That flag can drive the channel's interrupt line unless it is masked. Memory access is single-beat with a request/acknowledge handshake. A separate read port serves the fetch channel and a separate write port serves the store channel. Chaining the outgoing stream back into the incoming stream turns the pair into a memory-to-memory copier.

Top module: `msd_dma`

## Requirements
- R1: After reset, both channels read not busy and have all interrupt status bits clear. The fetch channel's mask reads 0x7F and the store channel's mask reads 0xFE. Both interrupt outputs, `rd_req`, `so_valid` and `si_ready` are low.
- R2: The fetch channel's registers decode at offsets 0x000-0x02B. The store channel's registers sit at the same offsets plus 0x800. A write to one channel leaves the other channel's registers unchanged.
- R3: The address-low register (offset 0x00) keeps bits 31:2 and reads zero in bits 1:0. The address-high register (offset 0x28) keeps bits 16:0, which become memory address bits 48:32 on the memory ports.
- R4: Writing the count register (offset 0x04) with a non-zero value in bits 31:2 starts a transfer of that many bytes, which is (bits 31:2) words. The address steps by 4 after every word, and address-low reads the next unused address once the transfer ends.
- R5: A count write whose bits 31:2 are zero is ignored. A count write while the channel is busy is also ignored.
- R6: The fetch channel drives `so_last` high with its final word only when bit 0 of the starting count write was one. It never drives `so_last` with any other word.
- R7: Bit 0 of the status register (offset 0x08) reads one from the start of a transfer until its last word completes.
- R8: Bit 1 of the interrupt status register (offset 0x14) is set when a transfer completes. Writing one to that bit clears it.
- R9: Writing one to a bit of the enable register (0x18) clears that mask bit. Writing one to a bit of the disable register (0x1C) sets it. The mask reads at 0x20. Only bits 6:0 exist in the fetch channel and only bits 7:1 in the store channel, and writes to other bits change nothing.
- R10: With bit 23 of a channel's control register (0x0C) set, that channel reverses the byte order of every word it moves.
- R11: A channel's interrupt output is high exactly when some status bit is set whose mask bit is clear.
- R12: The store channel holds `si_ready` low whenever its memory write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| src_irq | output | 1 | Fetch channel interrupt |
| dst_irq | output | 1 | Store channel interrupt |
| rd_req | output | 1 | Memory read request, held until rd_ack |
| rd_addr | output | 49 | Memory read byte address |
| rd_ack | input | 1 | Memory read acknowledge, data valid with it |
| rd_data | input | 32 | Memory read data |
| wr_req | output | 1 | Memory write request, held until wr_ack |
| wr_addr | output | 49 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ack | input | 1 | Memory write acknowledge |
| so_valid | output | 1 | Outgoing stream word valid |
| so_data | output | 32 | Outgoing stream word |
| so_last | output | 1 | Outgoing stream end-of-stream marker |
| so_ready | input | 1 | Outgoing stream ready |
| si_valid | input | 1 | Incoming stream word valid |
| si_data | input | 32 | Incoming stream word |
| si_ready | output | 1 | Incoming stream ready |

## Verification
The bench builds the block with its default parameters. These are a 17-bit address-high field, a 30-bit word counter and a 0x800 channel spacing, so it drives the full 49-bit address and both real channel windows. It loops the outgoing stream into the incoming one. Each copy therefore exercises both channels together, and every pairing of the two byte-swap options shows up in the copied data. With the full-width high field, a value near the top of the range can be followed out to bits 48:32 of `rd_addr`.

// File: rtl/msd_pkg.sv
package msd_pkg;

   // per-channel register offsets (byte offset inside a channel window)
   localparam logic [7:0] OFF_ADDR_LO = 8'h00;
   localparam logic [7:0] OFF_SIZE    = 8'h04;
   localparam logic [7:0] OFF_STAT    = 8'h08;
   localparam logic [7:0] OFF_CTRL    = 8'h0C;
   localparam logic [7:0] OFF_IST     = 8'h14;
   localparam logic [7:0] OFF_IEN     = 8'h18;
   localparam logic [7:0] OFF_IDIS    = 8'h1C;
   localparam logic [7:0] OFF_IMASK   = 8'h20;
   localparam logic [7:0] OFF_ADDR_HI = 8'h28;

   localparam int SWAP_BIT = 23;
   localparam int DONE_BIT = 1;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_MEM,
      ENG_OUT
   } eng_state_t;

   function automatic logic [31:0] swap_bytes(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/msd_regs.sv
module msd_regs
   import msd_pkg::*;
#(
   parameter int         CNT_W     = 30,
   parameter int         HI_W      = 17,
   parameter logic [7:0] IRQ_VALID = 8'h7F,
   localparam int        LO_W      = 30,
   localparam int        WA_W      = LO_W + HI_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [7:0]      off,
   input  logic [31:0]     wdata,
   output logic [31:0]     rdata,
   input  logic            step,
   output logic            busy,
   output logic [WA_W-1:0] word_addr,
   output logic            swap,
   output logic            eos_last,
   output logic            irq
);

   if (CNT_W < 1 || CNT_W > 30) begin : g_bad_cnt
      $error("CNT_W must lie in 1..30");
   end
   if (HI_W < 1 || HI_W > 32) begin : g_bad_hi
      $error("HI_W must lie in 1..32");
   end

   logic             busy_q, eos_q, swap_q;
   logic [CNT_W-1:0] remain_q;
   logic [WA_W-1:0]  wa_q;
   logic [7:0]       ist_q, imask_q;
   logic [7:0]       wbits;
   logic             last_word;
   logic             unused_wdata;

   assign wbits        = wdata[7:0] & IRQ_VALID;
   assign last_word    = (remain_q == CNT_W'(1));
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         eos_q    <= 1'b0;
         swap_q   <= 1'b0;
         remain_q <= '0;
         wa_q     <= '0;
         ist_q    <= '0;
         imask_q  <= IRQ_VALID;
      end else begin
         if (wr_en) begin
            case (off)
               OFF_ADDR_LO: if (!busy_q) wa_q[LO_W-1:0] <= wdata[31:2];
               OFF_ADDR_HI: if (!busy_q) wa_q[WA_W-1:LO_W] <= wdata[HI_W-1:0];
               OFF_SIZE: begin
                  if (!busy_q && wdata[CNT_W+1:2] != '0) begin
                     remain_q <= wdata[CNT_W+1:2];
                     eos_q    <= wdata[0];
                     busy_q   <= 1'b1;
                  end
               end
               OFF_CTRL: swap_q  <= wdata[SWAP_BIT];
               OFF_IST:  ist_q   <= ist_q & ~wbits;
               OFF_IEN:  imask_q <= imask_q & ~wbits;
               OFF_IDIS: imask_q <= imask_q | wbits;
               default: ;
            endcase
         end
         // hardware completion wins over a same-cycle clear
         if (step) begin
            wa_q     <= wa_q + WA_W'(1);
            remain_q <= remain_q - CNT_W'(1);
            if (last_word) begin
               busy_q          <= 1'b0;
               ist_q[DONE_BIT] <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (off)
         OFF_ADDR_LO: rdata = {wa_q[LO_W-1:0], 2'b00};
         OFF_ADDR_HI: rdata = 32'(wa_q[WA_W-1:LO_W]);
         OFF_SIZE:    rdata = 32'({remain_q, 1'b0, eos_q});
         OFF_STAT:    rdata = 32'(busy_q);
         OFF_CTRL:    rdata = 32'(swap_q) << SWAP_BIT;
         OFF_IST:     rdata = 32'(ist_q & IRQ_VALID);
         OFF_IMASK:   rdata = 32'(imask_q & IRQ_VALID);
         default:     rdata = '0;
      endcase
   end

   assign busy      = busy_q;
   assign word_addr = wa_q;
   assign swap      = swap_q;
   assign eos_last  = eos_q && last_word;
   assign irq       = |(ist_q & ~imask_q & IRQ_VALID);

   // R4: the engine only reports a finished word for a running channel
   a_r4_step_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> busy_q);

   // R7: busy drops only after the last word completed
   a_r7_busy_fall_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(step && last_word));

   // R8: completion of the last word raises the done flag
   a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      step && last_word |=> ist_q[DONE_BIT]);

   // R5: a count write during a transfer leaves the count alone
   a_r5_busy_size_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && wr_en && off == OFF_SIZE && !step |=> remain_q == $past(remain_q));

endmodule

// File: rtl/msd_src_eng.sv
module msd_src_eng
   import msd_pkg::*;
#(
   parameter int  WA_W   = 47,
   localparam int ADDR_W = WA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              swap,
   input  logic [WA_W-1:0]   word_addr,
   input  logic              eos_last,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [31:0]       rd_data,
   output logic              so_valid,
   output logic [31:0]       so_data,
   output logic              so_last,
   input  logic              so_ready,
   output logic              step
);

   eng_state_t  state_q;
   logic [31:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         data_q  <= '0;
      end else begin
         case (state_q)
            ENG_IDLE: if (busy) state_q <= ENG_MEM;
            ENG_MEM: begin
               if (rd_ack) begin
                  data_q  <= swap ? swap_bytes(rd_data) : rd_data;
                  state_q <= ENG_OUT;
               end
            end
            ENG_OUT: if (so_ready) state_q <= ENG_IDLE;
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assign rd_req   = (state_q == ENG_MEM);
   assign rd_addr  = {word_addr, 2'b00};
   assign so_valid = (state_q == ENG_OUT);
   assign so_data  = data_q;
   assign so_last  = so_valid && eos_last;
   assign step     = so_valid && so_ready;

   // R6: an offered word and its end marker hold until taken
   a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      so_valid && !so_ready |=> so_valid && $stable(so_data) && $stable(so_last));

endmodule

// File: rtl/msd_dst_eng.sv
module msd_dst_eng
   import msd_pkg::*;
#(
   parameter int  WA_W   = 47,
   localparam int ADDR_W = WA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              swap,
   input  logic [WA_W-1:0]   word_addr,
   input  logic              si_valid,
   input  logic [31:0]       si_data,
   output logic              si_ready,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   input  logic              wr_ack,
   output logic              step
);

   eng_state_t  state_q;
   logic [31:0] data_q;

   assign si_ready = busy && (state_q == ENG_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         data_q  <= '0;
      end else begin
         case (state_q)
            ENG_IDLE: begin
               if (si_valid && si_ready) begin
                  data_q  <= swap ? swap_bytes(si_data) : si_data;
                  state_q <= ENG_MEM;
               end
            end
            ENG_MEM: if (wr_ack) state_q <= ENG_IDLE;
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assign wr_req  = (state_q == ENG_MEM);
   assign wr_addr = {word_addr, 2'b00};
   assign wr_data = data_q;
   assign step    = wr_req && wr_ack;

   // R12: the stream is stalled while a write waits for memory
   a_r12_stall_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> !si_ready);

endmodule

// File: rtl/msd_dma.sv
module msd_dma
   import msd_pkg::*;
#(
   parameter int         ADDR_HI_W    = 17,
   parameter int         CNT_W        = 30,
   parameter int         REG_AW       = 12,
   parameter int         DST_BASE     = 32'h800,
   parameter logic [7:0] SRC_IRQ_BITS = 8'h7F,
   parameter logic [7:0] DST_IRQ_BITS = 8'hFE,
   localparam int        WA_W         = 30 + ADDR_HI_W,
   localparam int        ADDR_W       = WA_W + 2,
   localparam int        SEL_BIT      = $clog2(DST_BASE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              src_irq,
   output logic              dst_irq,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [31:0]       rd_data,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   input  logic              wr_ack,
   output logic              so_valid,
   output logic [31:0]       so_data,
   output logic              so_last,
   input  logic              so_ready,
   input  logic              si_valid,
   input  logic [31:0]       si_data,
   output logic              si_ready
);

   if ((DST_BASE & (DST_BASE - 1)) != 0 || DST_BASE < 256 ||
       DST_BASE >= (1 << REG_AW)) begin : g_bad_base
      $error("DST_BASE must be a power of two between 0x100 and the register space");
   end

   localparam logic [REG_AW-1:0] DEC_MASK = ~(REG_AW'(DST_BASE) | REG_AW'(255));

   logic       dec_hit, dec_sel;
   logic [7:0] dec_off;

   assign dec_hit = (reg_addr & DEC_MASK) == '0;
   assign dec_sel = reg_addr[SEL_BIT];
   assign dec_off = reg_addr[7:0];

   logic [1:0]            ch_busy, ch_swap, ch_eos, ch_step, ch_irq;
   logic [1:0][WA_W-1:0]  ch_wa;
   logic [1:0][31:0]      ch_rdata;
   logic                  unused_dst_eos;

   assign unused_dst_eos = ch_eos[1];

   for (genvar gi = 0; gi < 2; gi++) begin : g_ch
      localparam logic [7:0] VBITS = (gi == 0) ? SRC_IRQ_BITS : DST_IRQ_BITS;

      msd_regs #(
         .CNT_W    (CNT_W),
         .HI_W     (ADDR_HI_W),
         .IRQ_VALID(VBITS)
      ) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (reg_wr && dec_hit && (dec_sel == 1'(gi))),
         .off      (dec_off),
         .wdata    (reg_wdata),
         .rdata    (ch_rdata[gi]),
         .step     (ch_step[gi]),
         .busy     (ch_busy[gi]),
         .word_addr(ch_wa[gi]),
         .swap     (ch_swap[gi]),
         .eos_last (ch_eos[gi]),
         .irq      (ch_irq[gi])
      );

      if (gi == 0) begin : g_src
         msd_src_eng #(.WA_W(WA_W)) u_eng (
            .clk      (clk),
            .rst_n    (rst_n),
            .busy     (ch_busy[gi]),
            .swap     (ch_swap[gi]),
            .word_addr(ch_wa[gi]),
            .eos_last (ch_eos[gi]),
            .rd_req   (rd_req),
            .rd_addr  (rd_addr),
            .rd_ack   (rd_ack),
            .rd_data  (rd_data),
            .so_valid (so_valid),
            .so_data  (so_data),
            .so_last  (so_last),
            .so_ready (so_ready),
            .step     (ch_step[gi])
         );
      end else begin : g_dst
         msd_dst_eng #(.WA_W(WA_W)) u_eng (
            .clk      (clk),
            .rst_n    (rst_n),
            .busy     (ch_busy[gi]),
            .swap     (ch_swap[gi]),
            .word_addr(ch_wa[gi]),
            .si_valid (si_valid),
            .si_data  (si_data),
            .si_ready (si_ready),
            .wr_req   (wr_req),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .wr_ack   (wr_ack),
            .step     (ch_step[gi])
         );
      end
   end

   assign reg_rdata = dec_hit ? ch_rdata[dec_sel] : '0;
   assign src_irq   = ch_irq[0];
   assign dst_irq   = ch_irq[1];

endmodule

// File: tb/msd_dma_test.sv
module msd_dma_test;

   localparam int ADDR_W = 49;
   localparam logic [11:0] DB = 12'h800;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [11:0]       reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              src_irq, dst_irq;
   logic              rd_req, wr_req;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic              rd_ack = 1'b0, wr_ack = 1'b0;
   logic [31:0]       rd_data = '0;
   logic [31:0]       wr_data;
   logic              so_valid, so_last, si_ready;
   logic [31:0]       so_data;

   always #2.5 clk = ~clk;

   msd_dma uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .src_irq(src_irq), .dst_irq(dst_irq),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
      .so_valid(so_valid), .so_data(so_data), .so_last(so_last), .so_ready(si_ready),
      .si_valid(so_valid), .si_data(so_data), .si_ready(si_ready)
   );

   function automatic logic [31:0] pat(input int w);
      return 32'h1A2B3C4D ^ (32'(w) * 32'h01000107);
   endfunction

   function automatic logic [31:0] bsw(input logic [31:0] a);
      return {a[7:0], a[15:8], a[23:16], a[31:24]};
   endfunction

   // memory model: one-cycle acknowledge
   logic [31:0] dmem [256];
   always @(posedge clk) begin
      rd_ack  <= rd_req && !rd_ack;
      rd_data <= pat(int'(rd_addr[9:2]));
      wr_ack  <= wr_req && !wr_ack;
      if (wr_req && !wr_ack) dmem[wr_addr[9:2]] <= wr_data;
   end

   // monitors, sampled at the falling edge
   int beats = 0, last_cnt = 0, last_at = 0, wr_cnt = 0, stall_err = 0;
   logic [ADDR_W-1:0] last_rd_addr = '0;
   always @(negedge clk) begin
      if (so_valid && si_ready) begin
         beats = beats + 1;
         if (so_last) begin
            last_cnt = last_cnt + 1;
            last_at  = beats;
         end
      end
      if (wr_req && wr_ack) wr_cnt = wr_cnt + 1;
      if (wr_req && si_ready) stall_err = stall_err + 1;
      if (rd_req) last_rd_addr = rd_addr;
   end

   int checks = 0, errors = 0;

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic wreg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rreg(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle(input logic [11:0] stat_addr);
      logic [31:0] s;
      for (int i = 0; i < 2000; i++) begin
         rreg(stat_addr, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   task automatic clear_mon();
      @(negedge clk);
      beats = 0; last_cnt = 0; last_at = 0; wr_cnt = 0;
   endtask

   // vector: [7:0] src word idx, [15:8] dst word idx, [23:16] words,
   //         [24] end marker, [25] fetch swap, [26] store swap
   localparam logic [31:0] VEC [4] = '{
      32'h0101_4010,
      32'h0205_5020,
      32'h0503_6030,
      32'h0704_7008
   };

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // ---- R1 reset state
      rreg(12'h008, v);       chk("R1 src status", v, 0);
      rreg(DB + 12'h008, v);  chk("R1 dst status", v, 0);
      rreg(12'h020, v);       chk("R1 src mask", v, 32'h7F);
      rreg(DB + 12'h020, v);  chk("R1 dst mask", v, 32'hFE);
      rreg(12'h014, v);       chk("R1 src ist", v, 0);
      chk("R1 irq lines", {src_irq, dst_irq}, 0);
      chk("R1 stream/mem idle", {rd_req, so_valid, si_ready}, 0);

      // ---- R2 channel windows
      wreg(12'h000, 32'h0000_0440);
      wreg(DB + 12'h000, 32'h0000_1234);
      rreg(12'h000, v);       chk("R2 src addr untouched", v, 32'h440);
      rreg(DB + 12'h000, v);  chk("R2 dst addr at +0x800", v, 32'h1234);

      // enable done interrupt on both channels
      wreg(12'h018, 32'h2);
      wreg(DB + 12'h018, 32'h2);

      // ---- vector table: copies through the looped stream
      for (int n = 0; n < 4; n++) begin
         int s, d, w, mism;
         logic eos, ss, ds;
         s = int'(VEC[n][7:0]); d = int'(VEC[n][15:8]); w = int'(VEC[n][23:16]);
         eos = VEC[n][24]; ss = VEC[n][25]; ds = VEC[n][26];
         wreg(12'h00C, 32'(ss) << 23);
         wreg(DB + 12'h00C, 32'(ds) << 23);
         wreg(12'h000, 32'(s * 4));
         wreg(12'h028, 0);
         wreg(DB + 12'h000, 32'(d * 4));
         wreg(DB + 12'h028, 0);
         clear_mon();
         wreg(DB + 12'h004, 32'(w) << 2);
         wreg(12'h004, (32'(w) << 2) | 32'(eos));
         rreg(12'h008, v);     chk("R7 src busy while running", v, 1);
         wait_idle(DB + 12'h008);
         mism = 0;
         for (int k = 0; k < w; k++) begin
            logic [31:0] e;
            e = pat(s + k);
            if (ss ^ ds) e = bsw(e);
            if (dmem[d + k] !== e) mism++;
         end
         chk("R4/R10 copied words", 64'(mism), 0);
         chk("R4 word count", 64'(wr_cnt), 64'(w));
         chk("R6 end marker count", 64'(last_cnt), 64'(eos));
         chk("R6 end marker position", 64'(last_at), eos ? 64'(w) : 0);
         rreg(12'h000, v);     chk("R4 src address advanced", v, 32'((s + w) * 4));
         rreg(DB + 12'h008, v); chk("R7 dst idle after end", v, 0);
         rreg(12'h014, v);     chk("R8 src done", v, 32'h2);
         rreg(DB + 12'h014, v); chk("R8 dst done", v, 32'h2);
         chk("R11 irq raised", {src_irq, dst_irq}, 2'b11);
         wreg(12'h014, 32'h2);
         wreg(DB + 12'h014, 32'h2);
         rreg(DB + 12'h014, v); chk("R8 done cleared", v, 0);
         chk("R11 irq dropped", {src_irq, dst_irq}, 2'b00);
      end

      // ---- R5 ignored count writes
      wreg(12'h00C, 0);
      wreg(DB + 12'h00C, 0);
      wreg(12'h004, 32'h0000_0003);
      rreg(12'h008, v);       chk("R5 zero count ignored", v, 0);
      wreg(DB + 12'h000, 32'h0000_0240);
      wreg(12'h000, 32'h0);
      clear_mon();
      wreg(DB + 12'h004, 32'h8);
      rreg(DB + 12'h008, v);  chk("R7 dst busy awaiting stream", v, 1);
      wreg(DB + 12'h004, 32'h14);
      wreg(12'h004, 32'h8);
      wait_idle(DB + 12'h008);
      chk("R5 busy count write ignored", 64'(wr_cnt), 2);
      rreg(DB + 12'h000, v);  chk("R5 dst address after 2 words", v, 32'h248);
      wreg(12'h014, 32'h2);
      wreg(DB + 12'h014, 32'h2);

      // ---- R3 address fields, R11 masking
      wreg(12'h01C, 32'h2);
      wreg(DB + 12'h01C, 32'h2);
      wreg(12'h000, 32'hFFFF_FFFF);
      rreg(12'h000, v);       chk("R3 low bits read zero", v, 32'hFFFF_FFFC);
      wreg(12'h028, 32'hFFFF_FFFF);
      rreg(12'h028, v);       chk("R3 high field width", v, 32'h1FFFF);
      wreg(12'h000, 32'h0000_0100);
      wreg(12'h028, 32'h0001_5A5A);
      wreg(DB + 12'h000, 32'h0000_0300);
      wreg(DB + 12'h028, 0);
      wreg(DB + 12'h004, 32'h4);
      wreg(12'h004, 32'h4);
      wait_idle(DB + 12'h008);
      chk("R3 high bits on read port", 64'(last_rd_addr), 64'(49'h1_5A5A_0000_0100));
      rreg(12'h014, v);       chk("R8 src done while masked", v, 32'h2);
      chk("R11 masked irq low", {src_irq, dst_irq}, 2'b00);
      wreg(12'h018, 32'h2);
      #1;
      chk("R11 unmask raises src irq", {src_irq, dst_irq}, 2'b10);

      // ---- R9 mask ranges
      wreg(12'h01C, 32'hFF);
      rreg(12'h020, v);       chk("R9 src disable range", v, 32'h7F);
      wreg(DB + 12'h01C, 32'hFF);
      rreg(DB + 12'h020, v);  chk("R9 dst disable range", v, 32'hFE);
      wreg(DB + 12'h018, 32'h01);
      rreg(DB + 12'h020, v);  chk("R9 dst bit 0 absent", v, 32'hFE);
      wreg(12'h018, 32'h80);
      rreg(12'h020, v);       chk("R9 src bit 7 absent", v, 32'h7F);
      wreg(12'h018, 32'hFF);
      rreg(12'h020, v);       chk("R9 src enable all", v, 0);

      chk("R12 no ready during pending write", 64'(stall_err), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule